// File: doc/BRIEF.md
# Staged Warning Lamp Sequencer

This block drives five warning lamps from a small synchronous state machine. While the run switch is on, the lamps light in cumulative groups on successive clock periods: first the front pair, then the middle pair joins them, then the last lamp. With all five lit, the next period clears them and the build-up starts again.

Turning the switch off darkens every lamp at the next clock edge and returns the sequence to its start. The state lives in a two-bit register. The lamp outputs are decoded from that register alone, so they change only at clock edges. A synchronous active-high reset puts the machine in its dark starting state.

Top module: `warn_lamp_seq`

## Requirements
- R1: When `rst` is high at a rising edge, the block is in its start state after that edge and `lamps` reads 5'b00000. The lamp bit mapping is: bit 0 is lamp 1, and bit 4 is lamp 5.
- R2: From the start state, with `run` high at a rising edge, `lamps` reads 5'b00011 after that edge. Lamps 1 and 2 are lit.
- R3: From pattern 5'b00011, with `run` high at an edge, `lamps` reads 5'b01111 after that edge. Lamps 3 and 4 join lamps 1 and 2.
- R4: From pattern 5'b01111, with `run` high at an edge, `lamps` reads 5'b11111 after that edge. Lamp 5 joins the other four.
- R5: From pattern 5'b11111, with `run` high at an edge, `lamps` returns to 5'b00000. The four-step pattern then repeats for as long as `run` stays high.
- R6: When `run` is low at a rising edge, `lamps` reads 5'b00000 after that edge, whatever the prior pattern was. The next edge with `run` high then gives 5'b00011.
- R7: `lamps` depends only on the stored state. A change of `run` between edges leaves `lamps` unchanged until the next rising edge.
- R8: Out of reset, `lamps` only ever shows one of the four patterns 5'b00000, 5'b00011, 5'b01111 or 5'b11111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state advances on the rising edge |
| rst | input | 1 | Synchronous active-high reset to the start state |
| run | input | 1 | Run switch; high lets the sequence advance, low forces the start state |
| lamps | output | 5 | Lamp outputs; bit 0 is lamp 1, bit 4 is lamp 5 |

## Verification
On every cycle, the assertions check each single-step transition of the lamp pattern. They also check the forced return to dark when the switch is off or reset is applied, and that the pattern is always one of the four legal patterns. The Moore property cannot be seen at clock edges, so only the bench shows it: it toggles the switch partway through a period and confirms that the lamps hold until the edge. The bench scenarios also show the full wrap over several rounds, and a restart after an interruption part-way through the sequence.

// File: rtl/warn_lamp_seq.sv
module warn_lamp_seq (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  output logic [4:0] lamps
);

  logic [1:0] phase;
  logic [1:0] phase_nx;

  assign phase_nx = run ? phase + 2'd1 : 2'd0;

  always_ff @(posedge clk) begin
    if (rst) phase <= 2'd0;
    else     phase <= phase_nx;
  end

  assign lamps[1:0] = {2{|phase}};
  assign lamps[3:2] = {2{phase[1]}};
  assign lamps[4]   = &phase;

endmodule

// File: rtl/warn_lamp_seq_chk.sv
module warn_lamp_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       run,
  input logic [4:0] lamps
);

  a_r1_reset_dark: assert property (@(posedge clk) rst |=> lamps == 5'b00000);

  a_r2_first_pair: assert property (@(posedge clk) disable iff (rst)
    (run && lamps == 5'b00000) |=> lamps == 5'b00011);

  a_r3_second_pair: assert property (@(posedge clk) disable iff (rst)
    (run && lamps == 5'b00011) |=> lamps == 5'b01111);

  a_r4_all_lit: assert property (@(posedge clk) disable iff (rst)
    (run && lamps == 5'b01111) |=> lamps == 5'b11111);

  a_r5_wrap: assert property (@(posedge clk) disable iff (rst)
    (run && lamps == 5'b11111) |=> lamps == 5'b00000);

  a_r6_switch_off: assert property (@(posedge clk) disable iff (rst)
    !run |=> lamps == 5'b00000);

  a_r8_legal_pattern: assert property (@(posedge clk) disable iff (rst)
    $past(rst) || lamps == 5'b00000 || lamps == 5'b00011 ||
    lamps == 5'b01111 || lamps == 5'b11111);

endmodule

bind warn_lamp_seq warn_lamp_seq_chk u_chk (
  .clk  (clk),
  .rst  (rst),
  .run  (run),
  .lamps(lamps)
);

// File: tb/sim_warn_lamp_seq.sv
module sim_warn_lamp_seq;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run = 1'b0;
  logic [4:0] lamps;

  int checks = 0;
  int failures = 0;

  warn_lamp_seq u0 (.clk(clk), .rst(rst), .run(run), .lamps(lamps));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic [4:0] exp);
    checks++;
    if (lamps !== exp) begin
      failures++;
      $display("FAIL %s lamps=%b expected=%b", tag, lamps, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; run = 1'b1;
    step(); step();
    chk("R1 reset", 5'b00000);
    rst = 1'b0; run = 1'b0;
    step();
    chk("R6 idle stays dark", 5'b00000);
  endtask

  task automatic t_build();
    run = 1'b1;
    step(); chk("R2 first pair", 5'b00011);
    step(); chk("R3 second pair", 5'b01111);
    step(); chk("R4 all lit", 5'b11111);
    step(); chk("R5 wrap dark", 5'b00000);
  endtask

  task automatic t_rounds();
    logic [4:0] pat [4] = '{5'b00011, 5'b01111, 5'b11111, 5'b00000};
    run = 1'b1;
    for (int r = 0; r < 3; r++)
      for (int k = 0; k < 4; k++) begin
        step(); chk("R5 repeat", pat[k]);
      end
  endtask

  task automatic t_interrupt();
    run = 1'b1;
    step(); step(); step();
    chk("R4 before off", 5'b11111);
    run = 1'b0;
    #1 chk("R7 held mid-period", 5'b11111);
    step(); chk("R6 off darkens", 5'b00000);
    run = 1'b1;
    step(); chk("R6 restart from first pair", 5'b00011);
    run = 1'b0;
    step(); chk("R6 off from first pair", 5'b00000);
  endtask

  task automatic t_midcycle();
    run = 1'b0;
    step();
    run = 1'b1;
    #1 chk("R7 no change before edge", 5'b00000);
    step(); chk("R7 change at edge", 5'b00011);
    run = 1'b1;
    rst = 1'b1;
    step(); chk("R1 reset mid-sequence", 5'b00000);
    rst = 1'b0;
    step(); chk("R2 after reset", 5'b00011);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2;
    t_reset();
    t_build();
    t_rounds();
    t_interrupt();
    t_midcycle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule